// File: doc/BRIEF.md
# Banked Flash Read Router

This block sits in the read path of a flash array that is split into independent banks, each holding many sectors. An embedded program or erase may be running in at most one bank at a time. Every read is routed to one of two sources. Reads aimed at a bank with no operation running go to the array memory. Reads aimed at the busy bank get a status word, so a bank that is erasing or programming never holds up reads to the other banks.

When the running operation is suspended, reads to the busy bank come from the array again. The one exception is the sector under operation: that sector keeps answering with status and also raises an error flag. Array data and status words both come back exactly one clock after the read strobe. The array itself sits outside the block as a synchronous memory port with one cycle of latency.

Top module: `flashrd_router`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_valid` and `rd_err` are low. The status toggle bit is cleared, so the first status read after reset reports bit 0 as 0.
- R2: The bank of a read is the top log2(NUM_BANKS) bits of `rd_addr`, and its sector is `rd_addr[ADDR_W-1:SECT_OFF_W]`. With the defaults, the bank is `rd_addr[11:10]` and the sector is `rd_addr[11:6]`.
- R3: While `busy_vld` is low, every read returns the array word at `rd_addr`.
- R4: While `busy_vld` is high and `susp` is low, a read whose bank equals `busy_bank` returns the status word instead of array data.
- R5: A read whose bank differs from `busy_bank` returns array data with the same one-cycle latency, and `rd_err` stays low.
- R6: While `busy_vld` and `susp` are both high, a read to the busy bank in a sector other than `susp_sector` returns array data.
- R7: While `busy_vld` and `susp` are both high, a read to sector `susp_sector` returns the status word with bit 2 set, and `rd_err` is high in the same cycle as `rd_valid`.
- R8: The status word layout is as follows. Bit 0 is the toggle. Bit 1 is `susp`. Bit 2 is the suspended-sector fault. Bit 3 is always 1. Bits [4 +: BANK_W] hold `busy_bank`. All other bits are 0.
- R9: The toggle bit inverts after every read that returns status. Consecutive status reads therefore alternate 0,1,0,... Array reads leave the toggle unchanged.
- R10: A read accepted in one cycle gives `rd_valid` high for exactly one cycle, the next one. A read in every cycle gives `rd_valid` in every following cycle, in order.
- R11: `mem_rd_en` is high only for reads routed to the array, and `mem_addr` equals `rd_addr` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one read per cycle |
| rd_addr | input | ADDR_W | Read word address |
| busy_vld | input | 1 | An embedded operation is active |
| busy_bank | input | BANK_W | Bank running the operation |
| susp | input | 1 | The active operation is suspended |
| susp_sector | input | ADDR_W-SECT_OFF_W | Sector under the suspended operation |
| mem_rd_en | output | 1 | Array memory read request |
| mem_addr | output | ADDR_W | Array memory address |
| mem_rdata | input | DATA_W | Array memory data, one cycle after request |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | Read result valid pulse |
| rd_err | output | 1 | Read hit the suspended sector |

## Verification
The bench targets four boundaries: reads on either side of a bank edge while a neighbouring bank is busy, a suspended bank read inside and just outside the active sector, toggle alternation across status reads with array reads mixed in, and back-to-back mixed-route reads. A design that decodes the bank from the wrong bits leaks status into a free bank, or array data out of the busy one. One that ignores suspend returns status for the whole bank. One that forgets the sector check hands out the half-erased sector's contents with no error. A broken toggle shows up as a repeated bit 0, and a stale route register shows up as the wrong source on the second of two back-to-back reads.

// File: rtl/flashrd_pkg.sv
package flashrd_pkg;

    typedef enum logic [1:0] {
        ROUTE_ARRAY  = 2'd0,
        ROUTE_STATUS = 2'd1,
        ROUTE_FAULT  = 2'd2
    } route_e;

    localparam int ST_TOGGLE   = 0;
    localparam int ST_SUSP     = 1;
    localparam int ST_FAULT    = 2;
    localparam int ST_BUSY     = 3;
    localparam int ST_BANK_LSB = 4;

    function automatic logic route_is_status(input route_e r);
        return (r == ROUTE_STATUS) || (r == ROUTE_FAULT);
    endfunction

endpackage

// File: rtl/flashrd_route_dec.sv
module flashrd_route_dec
    import flashrd_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int SECT_IDX_W = 6,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic [SECT_IDX_W-1:0] rd_sect,
    input  logic                  busy_vld,
    input  logic [BANK_W-1:0]     busy_bank,
    input  logic                  susp,
    input  logic [SECT_IDX_W-1:0] susp_sector,
    output route_e                route
);

    logic [BANK_W-1:0]    addr_bank;
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 in_busy_bank;
    logic                 sect_match;

    assign addr_bank = rd_sect[SECT_IDX_W-1 -: BANK_W];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = busy_vld
                           && (busy_bank == BANK_W'(b))
                           && (addr_bank == BANK_W'(b));
    end

    assign in_busy_bank = |bank_hit;
    assign sect_match   = (rd_sect == susp_sector);

    always_comb begin
        if (!in_busy_bank)   route = ROUTE_ARRAY;
        else if (!susp)      route = ROUTE_STATUS;
        else if (sect_match) route = ROUTE_FAULT;
        else                 route = ROUTE_ARRAY;
    end

endmodule

// File: rtl/flashrd_status.sv
module flashrd_status
    import flashrd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              fault,
    input  logic              susp,
    input  logic [BANK_W-1:0] bank,
    output logic [DATA_W-1:0] status_q
);

    logic              toggle_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        word                          = '0;
        word[ST_TOGGLE]               = toggle_q;
        word[ST_SUSP]                 = susp;
        word[ST_FAULT]                = fault;
        word[ST_BUSY]                 = 1'b1;
        word[ST_BANK_LSB +: BANK_W]   = bank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            toggle_q <= 1'b0;
            status_q <= '0;
        end else if (take) begin
            toggle_q <= ~toggle_q;
            status_q <= word;
        end
    end

endmodule

// File: rtl/flashrd_router.sv
module flashrd_router
    import flashrd_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int NUM_BANKS  = 4,
    parameter int SECT_OFF_W = 6,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int SECT_IDX_W = ADDR_W - SECT_OFF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  busy_vld,
    input  logic [BANK_W-1:0]     busy_bank,
    input  logic                  susp,
    input  logic [SECT_IDX_W-1:0] susp_sector,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  rd_err
);

    route_e            route;
    logic [DATA_W-1:0] status_q;
    logic              sel_status_q;
    logic              valid_q;
    logic              err_q;

    flashrd_route_dec #(
        .NUM_BANKS  (NUM_BANKS),
        .SECT_IDX_W (SECT_IDX_W)
    ) u_dec (
        .rd_sect     (rd_addr[ADDR_W-1:SECT_OFF_W]),
        .busy_vld    (busy_vld),
        .busy_bank   (busy_bank),
        .susp        (susp),
        .susp_sector (susp_sector),
        .route       (route)
    );

    flashrd_status #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) u_status (
        .clk      (clk),
        .rst      (rst),
        .take     (rd_en && route_is_status(route)),
        .fault    (route == ROUTE_FAULT),
        .susp     (susp),
        .bank     (busy_bank),
        .status_q (status_q)
    );

    assign mem_rd_en = rd_en && (route == ROUTE_ARRAY);
    assign mem_addr  = rd_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q      <= 1'b0;
            sel_status_q <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            valid_q      <= rd_en;
            sel_status_q <= rd_en && route_is_status(route);
            err_q        <= rd_en && (route == ROUTE_FAULT);
        end
    end

    assign rd_valid = valid_q;
    assign rd_err   = err_q;
    assign rd_data  = sel_status_q ? status_q : mem_rdata;

endmodule

// File: rtl/flashrd_router_chk.sv
module flashrd_router_chk #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int NUM_BANKS  = 4,
    parameter int SECT_OFF_W = 6,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int SECT_IDX_W = ADDR_W - SECT_OFF_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  rd_en,
    input logic [SECT_IDX_W-1:0] rd_sect,
    input logic                  busy_vld,
    input logic [BANK_W-1:0]     busy_bank,
    input logic                  susp,
    input logic [SECT_IDX_W-1:0] susp_sector,
    input logic                  mem_rd_en,
    input logic [DATA_W-1:0]     mem_rdata,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  rd_valid,
    input logic                  rd_err
);

    logic same_bank;
    assign same_bank = busy_vld && (rd_sect[SECT_IDX_W-1 -: BANK_W] == busy_bank);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r7_fault_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_en && same_bank && susp && rd_sect == susp_sector) |=> (rd_err && rd_data[2]));

    a_r5_other_bank: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy_vld && !same_bank) |=> (!rd_err && rd_data == mem_rdata));

    a_r4_busy_marker: assert property (@(posedge clk) disable iff (rst)
        (rd_en && same_bank && !susp) |=> (rd_data[3] && !rd_err
                                           && rd_data[4 +: BANK_W] == $past(busy_bank)));

    a_r11_mem_gated: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> rd_en);

    a_r1_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_valid);

endmodule

bind flashrd_router flashrd_router_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_BANKS  (NUM_BANKS),
    .SECT_OFF_W (SECT_OFF_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_sect     (rd_addr[ADDR_W-1:SECT_OFF_W]),
    .busy_vld    (busy_vld),
    .busy_bank   (busy_bank),
    .susp        (susp),
    .susp_sector (susp_sector),
    .mem_rd_en   (mem_rd_en),
    .mem_rdata   (mem_rdata),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .rd_err      (rd_err)
);

// File: tb/tb_flashrd_router.sv
`timescale 1ns/1ps
module tb_flashrd_router;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int NB     = 4;
    localparam int SOFF   = 6;
    localparam int BW     = 2;
    localparam int SW     = ADDR_W - SOFF;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              busy_vld = 1'b0;
    logic [BW-1:0]     busy_bank = '0;
    logic              susp = 1'b0;
    logic [SW-1:0]     susp_sector = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              rd_err;

    always #2.5 clk = ~clk;

    flashrd_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NB), .SECT_OFF_W(SOFF)) dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .busy_vld(busy_vld), .busy_bank(busy_bank), .susp(susp), .susp_sector(susp_sector),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err));

    function automatic logic [DATA_W-1:0] memf(input logic [ADDR_W-1:0] a);
        return DATA_W'(a * 37) ^ 16'h9C00;
    endfunction

    always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              err;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    logic tog   = 1'b0;
    bit   done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        exp_t e;
        logic st, flt, arr;
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        st  = busy_vld && (a[ADDR_W-1 -: BW] == busy_bank)
              && (!susp || a[ADDR_W-1:SOFF] == susp_sector);
        flt = st && susp;
        arr = !st;
        #0.5;
        chk({tag, " R11 mem_rd_en"}, 32'(mem_rd_en), 32'(arr));
        if (arr) chk({tag, " R11 mem_addr"}, 32'(mem_addr), 32'(a));
        if (st) begin
            e.data = '0;
            e.data[0] = tog;
            e.data[1] = susp;
            e.data[2] = flt;
            e.data[3] = 1'b1;
            e.data[4 +: BW] = busy_bank;
            tog = ~tog;
        end else begin
            e.data = memf(a);
        end
        e.err = flt;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic set_op(input logic bv, input logic [BW-1:0] bk,
                          input logic sp, input logic [SW-1:0] sc);
        @(negedge clk);
        rd_en = 1'b0;
        busy_vld = bv; busy_bank = bk; susp = sp; susp_sector = sc;
    endtask

    // Monitor: pops the expected item for each valid result (R10 ordering)
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected rd_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " data"}, 32'(rd_data), 32'(e.data));
                    chk({e.tag, " err"}, 32'(rd_err), 32'(e.err));
                end
            end else if (exp_q.size() > 1) begin
                chk("R10 missing rd_valid", 32'd0, 32'd1);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(rd_valid), 32'd0);
        chk("R1 err in reset", 32'(rd_err), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(rd_valid), 32'd0);
        chk("R1 err after reset", 32'(rd_err), 32'd0);

        // R3: no operation, every bank gives array data
        for (int b = 0; b < NB; b++) rd(ADDR_W'(b * 1024 + 5), "R3 idle read");
        idle(2);

        // R4/R8/R1: bank 2 busy, first status read toggle 0
        set_op(1'b1, 2'd2, 1'b0, '0);
        rd(12'h800, "R4 R1 busy bank first status");
        rd(12'hBFF, "R4 R9 busy bank second status");
        // R5/R2: bank edges next to busy bank
        rd(12'h7FF, "R5 R2 bank1 top edge");
        rd(12'hC00, "R5 R2 bank3 bottom edge");
        rd(12'h850, "R9 R8 status after array reads");
        rd(12'h010, "R5 bank0");
        idle(2);

        // R6/R7: suspended, sector 0x25 (addr 0x940..0x97F) in bank 2
        set_op(1'b1, 2'd2, 1'b1, 6'h25);
        rd(12'h940, "R7 suspended sector low");
        rd(12'h97F, "R7 suspended sector high");
        rd(12'h93F, "R6 sector below");
        rd(12'h980, "R6 sector above");
        rd(12'hC40, "R5 other bank while suspended");
        idle(2);

        // R10: back-to-back mixed routes, bank 0 busy not suspended
        set_op(1'b1, 2'd0, 1'b0, '0);
        for (int i = 0; i < 8; i++)
            rd(ADDR_W'((i % 2) ? (i * 300 + 1100) : (i * 17)), "R10 back-to-back");
        idle(2);

        // R3: operation finished, busy bank returns array again
        set_op(1'b0, 2'd0, 1'b0, '0);
        rd(12'h020, "R3 after completion");
        idle(3);
        chk("R10 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule